// File: doc/BRIEF.md
# Oversampled SPI Slave

This block is a mode 0 SPI slave that runs entirely on a fast internal system clock. The external serial clock, chip select and MOSI lines are treated as plain data. Each passes through a two-register synchronizer, and the block finds the serial clock's edges by comparing consecutive synchronized samples. No logic is clocked by the serial clock itself.

On the user side, a valid/ready pair hands the slave the next word to shift out on MISO. Each word received on MOSI is presented with a one-cycle valid strobe. A word handed over is held in a pending register until a word slot starts. It is released, and ready returns, once the master has clocked that word's first bit. If no word is pending when a slot starts, the slave shifts out zeros for that slot.

Top module: `spi_os_slave`

## Requirements
- R1: After reset, tx_ready is 1, rx_valid is 0 and miso_o is 0.
- R2: sclk_i, csn_i and mosi_i each pass through two registers before use. The block operates correctly when each serial clock phase lasts at least 4 system clock cycles, and csn_i falls at least 4 system cycles before the first rising serial clock edge.
- R3: MOSI is sampled at each synchronized rising serial clock edge, most significant bit first. After the WORD_W-th bit, rx_word holds the received word and rx_valid is high.
- R4: rx_valid is never high for two consecutive system clock cycles.
- R5: The most significant bit of the word for a slot appears on miso_o within 3 system cycles of csn_i falling. Each later bit appears within 3 system cycles of a falling serial clock edge. miso_o changes at no other time while chip select stays low.
- R6: A word is accepted on a cycle where tx_valid and tx_ready are both 1. tx_ready is 0 in the following cycle.
- R7: An accepted word is transmitted in the next word slot. tx_ready returns to 1 only after the first rising serial clock edge of that slot. A word accepted while chip select is high is kept until the next transfer.
- R8: If no word is pending at the start of a slot, the slot transmits all zeros. A word accepted during such a slot is sent in the following slot.
- R9: If csn_i rises before a word is complete, the bit count is cleared and no rx_valid is produced. The next transfer receives a full word from its first bit.
- R10: miso_o is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial clock from the master, asynchronous |
| csn_i | input | 1 | Chip select from the master, active low, asynchronous |
| mosi_i | input | 1 | Serial data from the master, asynchronous |
| miso_o | output | 1 | Serial data to the master |
| tx_word | input | WORD_W | Next word to transmit |
| tx_valid | input | 1 | tx_word is valid |
| tx_ready | output | 1 | The pending register is free to take a word |
| rx_word | output | WORD_W | Last word received |
| rx_valid | output | 1 | One-cycle strobe marking a new rx_word |

## Verification
The assertions take for granted that the master keeps to the timing window of R2. Under that window, synchronized serial clock edges are at least three cycles apart and never coincide with a chip select edge. They also assume that MOSI is stable around each rising edge. The bench drives all serial lines on the falling system clock edge. It holds every serial clock phase for a whole number of cycles, from four to sixteen, and gives chip select the same setup and hold. The user handshake is pulsed for a single cycle, and only while tx_ready is high.

// File: rtl/spi_os_slave.sv
module spi_os_slave #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);
  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  // [0],[1]: synchronizer stages; [2]: previous synchronized sample
  logic [2:0] sclk_q, csn_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      csn_q  <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk_i};
      csn_q  <= {csn_q[1:0], csn_i};
      mosi_q <= {mosi_q[0], mosi_i};
    end
  end

  wire rise_e   = sclk_q[1] & ~sclk_q[2];
  wire fall_e   = ~sclk_q[1] & sclk_q[2];
  wire cs_on    = ~csn_q[1];
  wire cs_start = cs_on & csn_q[2];

  logic [WORD_W-1:0] tx_sh, rx_sh, pend;
  logic              pend_full, from_pend, active;
  logic [CNT_W-1:0]  cnt;

  wire              at_boundary = (cnt == '0);
  wire [WORD_W-1:0] next_word   = pend_full ? pend : '0;

  assign tx_ready = ~pend_full;
  assign miso_o   = active & tx_sh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh     <= '0;
      rx_sh     <= '0;
      pend      <= '0;
      pend_full <= 1'b0;
      from_pend <= 1'b0;
      active    <= 1'b0;
      cnt       <= '0;
      rx_word   <= '0;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tx_valid && !pend_full) begin
        pend      <= tx_word;
        pend_full <= 1'b1;
      end
      if (!cs_on) begin
        active    <= 1'b0;
        cnt       <= '0;
        from_pend <= 1'b0;
      end else if (cs_start) begin
        active    <= 1'b1;
        tx_sh     <= next_word;
        from_pend <= pend_full;
        cnt       <= '0;
      end else if (rise_e) begin
        rx_sh <= {rx_sh[WORD_W-2:0], mosi_q[1]};
        cnt   <= cnt + CNT_W'(1);
        if (at_boundary && from_pend) begin
          pend_full <= 1'b0;
          from_pend <= 1'b0;
        end
        if (cnt == LAST_BIT) begin
          rx_word  <= {rx_sh[WORD_W-2:0], mosi_q[1]};
          rx_valid <= 1'b1;
        end
      end else if (fall_e) begin
        if (at_boundary) begin
          tx_sh     <= next_word;
          from_pend <= pend_full;
        end else begin
          tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  a_r3_valid_on_wrap: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (cnt == '0));

  a_r6_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r7_ready_after_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ready) |-> $past(rise_e));

  a_r5_miso_steady: assert property (@(posedge clk) disable iff (rst)
    (cs_on && active && !fall_e) |=> $stable(miso_o));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !cs_on |=> (!miso_o && !rx_valid));
endmodule

// File: tb/tb_spi_os_slave.sv
module tb_spi_os_slave;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic         miso;
  logic [W-1:0] tx_word = '0;
  logic         tx_valid = 1'b0;
  logic         tx_ready;
  logic [W-1:0] rx_word;
  logic         rx_valid;

  int n_cmp = 0, n_bad = 0, rxn = 0, wide = 0;
  logic         rv_prev = 1'b0;
  logic [W-1:0] rxcap [0:63];
  logic [W-1:0] mo [0:3];
  logic [W-1:0] ex [0:3];

  always #2 clk = ~clk;

  spi_os_slave #(.WORD_W(W)) dut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_word(rx_word), .rx_valid(rx_valid));

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        if (rxn < 64) rxcap[rxn] = rx_word;
        rxn = rxn + 1;
      end
      if (rx_valid && rv_prev) wide = wide + 1;
      rv_prev = rx_valid;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R6: single-cycle handshake
  task automatic load(input logic [W-1:0] w);
    chk("R6 ready before load", 32'(tx_ready), 32'd1);
    tx_word  = w;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R6 ready low after accept", 32'(tx_ready), 32'd0);
  endtask

  task automatic xfer(input int h, input int nw, input bit pre,
                      input bit do_load, input logic [W-1:0] lw);
    int base;
    logic [W-1:0] got;
    base = rxn;
    csn = 1'b0;
    tick(h);
    for (int k = 0; k < nw; k++) begin
      got = '0;
      for (int b = W - 1; b >= 0; b--) begin
        mosi = mo[k][b];
        if (k == 0 && b == W - 1 && pre)
          chk("R7 ready low before first bit", 32'(tx_ready), 32'd0);
        if (k == 0 && b == W - 4 && do_load) begin
          chk("R7 ready back after first bit", 32'(tx_ready), 32'd1);
          load(lw);
          tick(h - 1);
        end else begin
          tick(h);
        end
        got[b] = miso;
        sclk = 1'b1;
        tick(h);
        sclk = 1'b0;
      end
      chk($sformatf("R5 miso word %0d ratio %0d", k, h), 32'(got), 32'(ex[k]));
    end
    tick(h);
    csn = 1'b1;
    tick(h + 4);
    chk("R3 word count", 32'(rxn - base), 32'(nw));
    for (int k = 0; k < nw; k++)
      chk($sformatf("R3 rx word %0d ratio %0d", k, h), 32'(rxcap[base + k]), 32'(mo[k]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int hs [0:4];
    int h;
    int base;
    logic [W-1:0] a, b, c, d, e;
    hs[0] = 4; hs[1] = 5; hs[2] = 7; hs[3] = 11; hs[4] = 16;
    tick(5);
    rst = 1'b0;
    tick(2);
    chk("R1 ready", 32'(tx_ready), 32'd1);
    chk("R1 valid", 32'(rx_valid), 32'd0);
    chk("R1 miso", 32'(miso), 32'd0);

    for (int i = 0; i < 5; i++) begin
      h = hs[i];  // R2: h = 4 is the narrowest phase allowed
      a = W'(h * 29 + 8'h5A);
      b = W'(h * 71) ^ 8'hC3;
      c = W'(h * 13 + 1);
      d = W'(h * 45) | 8'h81;
      e = (i % 2 == 0) ? 8'h80 : 8'h01;

      // R7, R8: preloaded word, word loaded mid-slot, then an empty slot
      for (int k = 0; k < 3; k++) mo[k] = W'(h * 37 + k * 83) ^ 8'hA5;
      load(a);
      ex[0] = a; ex[1] = b; ex[2] = '0;
      xfer(h, 3, 1'b1, 1'b1, b);
      chk("R7 ready idle after use", 32'(tx_ready), 32'd1);
      chk("R10 miso idle", 32'(miso), 32'd0);

      // R8: nothing pending at start, word loaded during the zero slot
      mo[0] = 8'hFF; mo[1] = 8'h00;
      ex[0] = '0; ex[1] = c;
      xfer(h, 2, 1'b0, 1'b1, c);

      // R9: abort mid-word
      load(d);
      base = rxn;
      csn = 1'b0;
      tick(h);
      for (int q = 0; q < 3; q++) begin
        mosi = q[0];
        tick(h);
        sclk = 1'b1;
        tick(h);
        sclk = 1'b0;
      end
      tick(h);
      csn = 1'b1;
      tick(h + 4);
      chk("R9 no strobe on abort", 32'(rxn - base), 32'd0);
      chk("R9 ready after committed abort", 32'(tx_ready), 32'd1);
      mo[0] = W'(h * 19) ^ 8'h3C;
      ex[0] = '0;
      xfer(h, 1, 1'b0, 1'b0, '0);

      // R10, R7: word kept across idle, miso quiet meanwhile
      load(e);
      for (int q = 0; q < 4; q++) begin
        tick(h);
        chk("R10 miso low with cs high", 32'(miso), 32'd0);
      end
      mo[0] = ~e;
      ex[0] = e;
      xfer(h, 1, 1'b1, 1'b0, '0);
    end

    chk("R4 strobe width", 32'(wide), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule